// File: doc/BRIEF.md
# Sleep-Mode Power Sequencer

This block moves a region of user logic into a low-power sleep mode and back out again. It runs from a clock that never stops, such as a free-running on-chip oscillator. It watches one request line and drives the control inputs of the chip's clock gates and pad buffers. It has three outputs: a pad enable, a 16-bit vector of clock-network enables, and a flag that is high for as long as the region is not fully awake. When the pad enable is low, the pads tri-state their outputs and power down their input receivers. The gating cells, the pads and the oscillator sit outside the block.

The two transitions are ordered as mirror images. When going to sleep, the pads are silenced first and the clocks are stopped afterwards. When waking, the clocks start first and the pads are enabled last. Each transition has two waits, and each wait is set by a 6-bit input with a hardware minimum. The clock vector never switches in one step. It changes segment by segment, from the low bits to the high bits, over three consecutive edges. This spreads the change in supply current across several cycles.

The request line is synchronised inside the block. Any change of the request while a transition is in progress is held off until the machine settles. The request level present at that point is then acted on.

Top module: `sleep_pm_ctrl`

## Requirements
- R1: While reset is low and after it is released, `io_en` is 1, every bit of `clk_en` is 1 and `sleep_stat` is 0.
- R2: The request passes through two synchronising flops. If `sleep_req` changes between edges, the machine acts on it at the third rising edge after the change. That edge is called the start edge (E0 for entry, X0 for exit).
- R3: On entry, `sleep_stat` rises at E0. `io_en` falls at edge E0+A, where A is the effective pad-off wait.
- R4: On entry, with B the effective clock-off wait, `clk_en[5:0]` clear at E0+A+B+1, `clk_en[10:6]` at E0+A+B+2 and `clk_en[15:11]` at E0+A+B+3. The sleep state is reached on that last edge, and all outputs then hold while the request stays high.
- R5: On exit, with C the effective clock-on wait, `clk_en[5:0]` set at X0+C+1, `clk_en[10:6]` at X0+C+2 and `clk_en[15:11]` at X0+C+3.
- R6: On exit, with D the effective pad-on wait, `io_en` rises at X0+C+3+D. `sleep_stat` falls on that same edge.
- R7: Each wait input is 6 bits wide, so values up to 63 are accepted. An input below its minimum is raised to the minimum. The minimums are: pad-off 1, clock-off 11, clock-on 1, pad-on 40.
- R8: `sleep_stat` stays high on every edge from E0 up to the edge where `io_en` returns.
- R9: Changes of `sleep_req` during entry or exit do not alter the sequence in progress. Once the machine settles, the current synchronised level is acted on at the next edge. So a request that went low during entry starts the exit on the edge right after sleep is reached, and a request that went high during exit starts a new entry on the edge right after wake.
- R10: `io_en` is never high unless all 16 bits of `clk_en` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request, asynchronous; 1 asks for sleep |
| dly_io_off | input | 6 | Cycles from entry start to pads off (minimum 1) |
| dly_clk_off | input | 6 | Cycles from pads off to clock ramp-down start (minimum 11) |
| dly_clk_on | input | 6 | Cycles from exit start to clock ramp-up start (minimum 1) |
| dly_io_on | input | 6 | Cycles from last clock segment on to pads on (minimum 40) |
| io_en | output | 1 | Pad enable; 0 tri-states outputs and powers down inputs |
| clk_en | output | 16 | Clock-network enables, 1 = running |
| sleep_stat | output | 1 | High from entry start until exit is complete |

## Verification
The bench sweeps all 64 values of the pad-off wait, with the other three waits walked through their range at the same time. It checks every output on every cycle against arithmetic edge formulas. An off-by-one in a wait counter, or a skipped or fused ramp segment, therefore shows up as a cycle-level mismatch.

Each minimum is probed at one below, exactly at, and one above its value, together with the value 0. A design that fails to clamp would switch the pads or clocks early, or would stall with a zero count. Request glitches are injected during both entry and exit, and so is a request that flips and then stays flipped. A design that reacts mid-transition would abort the ramp. A design that forgets the settled level would sit in sleep or wake and never move on.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      ST_AWAKE = 2'd0,
      ST_ENTER = 2'd1,
      ST_SLEEP = 2'd2,
      ST_EXIT  = 2'd3
   } pmc_state_e;

   // Sub-phase inside a transition: first wait, second wait, clock ramp.
   typedef enum logic [1:0] {
      PH_WAIT1 = 2'd0,
      PH_WAIT2 = 2'd1,
      PH_RAMP  = 2'd2
   } pmc_phase_e;

   localparam int RAMP_SEGS = 3;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pmc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pmc_dly_timer.sv
module pmc_dly_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expire
);

   generate
      if (W < 2) begin : g_bad_width
         $error("pmc_dly_timer: W must be at least 2");
      end
   endgenerate

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - ONE;
   end

   // Loaded with N at an edge: expire is seen at the (N)th following edge.
   assign expire = (cnt == ONE);

   // Clamped values reach the timer; a zero load would never expire.
   p_load_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));

endmodule

// File: rtl/pmc_clk_ramp.sv
module pmc_clk_ramp #(
   parameter int EN_W    = 16,
   parameter int SPLIT_A = 6,
   parameter int SPLIT_B = 11
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [pmc_pkg::RAMP_SEGS-1:0] seg_stb,
   input  logic                          level,
   output logic [EN_W-1:0]               en
);

   localparam int NSEG = pmc_pkg::RAMP_SEGS;

   generate
      if (!(SPLIT_A > 0 && SPLIT_B > SPLIT_A && EN_W > SPLIT_B)) begin : g_bad_split
         $error("pmc_clk_ramp: need 0 < SPLIT_A < SPLIT_B < EN_W");
      end
   endgenerate

   function automatic logic [EN_W-1:0] span_mask(int lo, int hi);
      logic [EN_W-1:0] m;
      m = '0;
      for (int b = 0; b < EN_W; b++) begin
         if (b >= lo && b <= hi) m[b] = 1'b1;
      end
      return m;
   endfunction

   logic [EN_W-1:0] seg_mask [NSEG];

   generate
      for (genvar s = 0; s < NSEG; s++) begin : g_mask
         localparam int LO = (s == 0) ? 0 : ((s == 1) ? SPLIT_A : SPLIT_B);
         localparam int HI = (s == 0) ? SPLIT_A - 1 : ((s == 1) ? SPLIT_B - 1 : EN_W - 1);
         assign seg_mask[s] = span_mask(LO, HI);
      end
   endgenerate

   logic [EN_W-1:0] sel_mask;

   always_comb begin
      sel_mask = '0;
      for (int s = 0; s < NSEG; s++) begin
         if (seg_stb[s]) sel_mask = sel_mask | seg_mask[s];
      end
   end

   logic [EN_W-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '1;
      else        en_q <= (en_q & ~sel_mask) | ({EN_W{level}} & sel_mask);
   end

   assign en = en_q;

   // Only one segment may switch on any edge.
   p_one_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(seg_stb));

endmodule

// File: rtl/sleep_pm_ctrl.sv
module sleep_pm_ctrl #(
   parameter int DLY_W       = 6,
   parameter int EN_W        = 16,
   parameter int SPLIT_A     = 6,
   parameter int SPLIT_B     = 11,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_IO_OFF  = 1,
   parameter int MIN_CLK_OFF = 11,
   parameter int MIN_CLK_ON  = 1,
   parameter int MIN_IO_ON   = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic [DLY_W-1:0] dly_io_off,
   input  logic [DLY_W-1:0] dly_clk_off,
   input  logic [DLY_W-1:0] dly_clk_on,
   input  logic [DLY_W-1:0] dly_io_on,
   output logic             io_en,
   output logic [EN_W-1:0]  clk_en,
   output logic             sleep_stat
);

   import pmc_pkg::*;

   localparam int DLY_MAX = (1 << DLY_W) - 1;
   localparam logic [DLY_W-1:0] MIN1 = DLY_W'(MIN_IO_OFF);
   localparam logic [DLY_W-1:0] MIN2 = DLY_W'(MIN_CLK_OFF);
   localparam logic [DLY_W-1:0] MIN3 = DLY_W'(MIN_CLK_ON);
   localparam logic [DLY_W-1:0] MIN4 = DLY_W'(MIN_IO_ON);
   localparam logic [1:0]       LAST_STEP = 2'(RAMP_SEGS - 1);

   generate
      if (DLY_W < 2 || DLY_W > 16) begin : g_bad_dly_w
         $error("sleep_pm_ctrl: DLY_W out of range");
      end
      if (MIN_IO_OFF < 1 || MIN_IO_OFF > DLY_MAX ||
          MIN_CLK_OFF < 1 || MIN_CLK_OFF > DLY_MAX ||
          MIN_CLK_ON < 1 || MIN_CLK_ON > DLY_MAX ||
          MIN_IO_ON < 1 || MIN_IO_ON > DLY_MAX) begin : g_bad_min
         $error("sleep_pm_ctrl: each minimum must lie in 1..2**DLY_W-1");
      end
   endgenerate

   // ---------------- request synchroniser ----------------
   logic req_s;

   pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sleep_req),
      .q     (req_s)
   );

   // ---------------- clamped wait values ----------------
   logic [DLY_W-1:0] t_io_off, t_clk_off, t_clk_on, t_io_on;

   assign t_io_off  = (dly_io_off  < MIN1) ? MIN1 : dly_io_off;
   assign t_clk_off = (dly_clk_off < MIN2) ? MIN2 : dly_clk_off;
   assign t_clk_on  = (dly_clk_on  < MIN3) ? MIN3 : dly_clk_on;
   assign t_io_on   = (dly_io_on   < MIN4) ? MIN4 : dly_io_on;

   // ---------------- shared wait timer ----------------
   logic             tmr_load;
   logic [DLY_W-1:0] tmr_val;
   logic             tmr_exp;

   pmc_dly_timer #(.W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_exp)
   );

   // ---------------- sequencer ----------------
   pmc_state_e state_q, state_d;
   pmc_phase_e phase_q, phase_d;
   logic [1:0] step_q, step_d;
   logic       io_q, io_d;
   logic       stat_q, stat_d;
   logic [RAMP_SEGS-1:0] seg_stb;
   logic       ramp_level;

   always_comb begin
      state_d    = state_q;
      phase_d    = phase_q;
      step_d     = step_q;
      io_d       = io_q;
      stat_d     = stat_q;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      seg_stb    = '0;
      ramp_level = 1'b1;
      unique case (state_q)
         ST_AWAKE: begin
            if (req_s) begin
               state_d  = ST_ENTER;
               phase_d  = PH_WAIT1;
               stat_d   = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = t_io_off;
            end
         end
         ST_ENTER: begin
            ramp_level = 1'b0;
            unique case (phase_q)
               PH_WAIT1: begin
                  if (tmr_exp) begin
                     io_d     = 1'b0;
                     phase_d  = PH_WAIT2;
                     tmr_load = 1'b1;
                     tmr_val  = t_clk_off;
                  end
               end
               PH_WAIT2: begin
                  if (tmr_exp) begin
                     phase_d = PH_RAMP;
                     step_d  = 2'd0;
                  end
               end
               default: begin
                  seg_stb = RAMP_SEGS'(1) << step_q;
                  if (step_q == LAST_STEP) state_d = ST_SLEEP;
                  else                     step_d  = step_q + 2'd1;
               end
            endcase
         end
         ST_SLEEP: begin
            ramp_level = 1'b0;
            if (!req_s) begin
               state_d  = ST_EXIT;
               phase_d  = PH_WAIT1;
               tmr_load = 1'b1;
               tmr_val  = t_clk_on;
            end
         end
         default: begin
            ramp_level = 1'b1;
            unique case (phase_q)
               PH_WAIT1: begin
                  if (tmr_exp) begin
                     phase_d = PH_RAMP;
                     step_d  = 2'd0;
                  end
               end
               PH_RAMP: begin
                  seg_stb = RAMP_SEGS'(1) << step_q;
                  if (step_q == LAST_STEP) begin
                     phase_d  = PH_WAIT2;
                     tmr_load = 1'b1;
                     tmr_val  = t_io_on;
                  end else begin
                     step_d = step_q + 2'd1;
                  end
               end
               default: begin
                  if (tmr_exp) begin
                     io_d    = 1'b1;
                     stat_d  = 1'b0;
                     state_d = ST_AWAKE;
                  end
               end
            endcase
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         phase_q <= PH_WAIT1;
         step_q  <= 2'd0;
         io_q    <= 1'b1;
         stat_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         step_q  <= step_d;
         io_q    <= io_d;
         stat_q  <= stat_d;
      end
   end

   // ---------------- clock enable ramp ----------------
   pmc_clk_ramp #(.EN_W(EN_W), .SPLIT_A(SPLIT_A), .SPLIT_B(SPLIT_B)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .seg_stb (seg_stb),
      .level   (ramp_level),
      .en      (clk_en)
   );

   assign io_en      = io_q;
   assign sleep_stat = stat_q;

   // ---------------- assertions ----------------
   p_io_needs_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      io_en |-> (clk_en == '1));

   p_sleep_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP) |-> ((clk_en == '0) && !io_en && sleep_stat));

   p_stat_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_stat |-> (state_q == ST_AWAKE));

   p_enter_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AWAKE && req_s) |=> (state_q == ST_ENTER && sleep_stat));

   p_enter_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ENTER) |=> (state_q == ST_ENTER || state_q == ST_SLEEP));

   p_exit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXIT) |=> (state_q == ST_EXIT || state_q == ST_AWAKE));

   p_io_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(io_en) |-> (state_q == ST_ENTER && $past(clk_en) == '1));

endmodule

// File: tb/sleep_pm_ctrl_test.sv
`timescale 1ns/1ps
module sleep_pm_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_req = 1'b0;
   logic [5:0]  dly_io_off = '0, dly_clk_off = '0, dly_clk_on = '0, dly_io_on = '0;
   logic        io_en;
   logic [15:0] clk_en;
   logic        sleep_stat;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [15:0] SEG0 = 16'h003F;
   localparam logic [15:0] SEG1 = 16'h07C0;
   localparam logic [15:0] SEG2 = 16'hF800;

   always #2.5 clk = ~clk;

   sleep_pm_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .dly_io_off  (dly_io_off),
      .dly_clk_off (dly_clk_off),
      .dly_clk_on  (dly_clk_on),
      .dly_io_on   (dly_io_on),
      .io_en       (io_en),
      .clk_en      (clk_en),
      .sleep_stat  (sleep_stat)
   );

   function automatic int eff(int v, int mn);
      return (v < mn) ? mn : v;
   endfunction

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Entry: e0 = loop index of the start edge; drive=1 raises the request first.
   task automatic do_entry(int t1, int t2, int e0, bit drive, int g_at, int g_len,
                           bit g_restore, string tag);
      int a, b, base, total;
      logic [15:0] exp_clk;
      dly_io_off  = 6'(t1);
      dly_clk_off = 6'(t2);
      a = eff(t1, 1);
      b = eff(t2, 11);
      base = e0 + a + b;
      total = base + 3;
      if (drive) begin
         @(negedge clk);
         sleep_req = 1'b1;
      end
      for (int i = 1; i <= total; i++) begin
         @(posedge clk);
         #1;
         exp_clk = 16'hFFFF;
         if (i >= base + 1) exp_clk &= ~SEG0;
         if (i >= base + 2) exp_clk &= ~SEG1;
         if (i >= base + 3) exp_clk &= ~SEG2;
         chk((tag != "") ? tag : ((i <= e0) ? "R2" : "R8"), "sleep_stat",
             {15'd0, sleep_stat}, {15'd0, (i >= e0)});
         chk((tag != "") ? tag : "R3", "io_en", {15'd0, io_en}, {15'd0, !(i >= e0 + a)});
         chk((tag != "") ? tag : "R4", "clk_en", clk_en, exp_clk);
         if (g_len > 0 && i == g_at) sleep_req = 1'b0;
         if (g_len > 0 && g_restore && i == g_at + g_len) sleep_req = 1'b1;
      end
   endtask

   task automatic do_exit(int t3, int t4, int x0, bit drive, int g_at, int g_len,
                          bit g_restore, string tag);
      int c, d, base, done;
      logic [15:0] exp_clk;
      dly_clk_on = 6'(t3);
      dly_io_on  = 6'(t4);
      c = eff(t3, 1);
      d = eff(t4, 40);
      base = x0 + c;
      done = base + 3 + d;
      if (drive) begin
         @(negedge clk);
         sleep_req = 1'b0;
      end
      for (int i = 1; i <= done; i++) begin
         @(posedge clk);
         #1;
         exp_clk = 16'h0000;
         if (i >= base + 1) exp_clk |= SEG0;
         if (i >= base + 2) exp_clk |= SEG1;
         if (i >= base + 3) exp_clk |= SEG2;
         chk((tag != "") ? tag : "R8", "sleep_stat", {15'd0, sleep_stat}, {15'd0, !(i >= done)});
         chk((tag != "") ? tag : "R6", "io_en", {15'd0, io_en}, {15'd0, (i >= done)});
         chk((tag != "") ? tag : "R5", "clk_en", clk_en, exp_clk);
         if (g_len > 0 && i == g_at) sleep_req = 1'b1;
         if (g_len > 0 && g_restore && i == g_at + g_len) sleep_req = 1'b0;
      end
   endtask

   task automatic hold_check(int n, logic exp_io, logic [15:0] exp_clk, logic exp_stat, string tag);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         chk(tag, "io_en", {15'd0, io_en}, {15'd0, exp_io});
         chk(tag, "clk_en", clk_en, exp_clk);
         chk(tag, "sleep_stat", {15'd0, sleep_stat}, {15'd0, exp_stat});
      end
   endtask

   initial begin
      #(5.0 * 190000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state, during and after reset
      sleep_req = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "io_en", {15'd0, io_en}, 16'd1);
      chk("R1", "clk_en", clk_en, 16'hFFFF);
      chk("R1", "sleep_stat", {15'd0, sleep_stat}, 16'd0);
      sleep_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      hold_check(5, 1'b1, 16'hFFFF, 1'b0, "R1");

      // Boundary waits around each minimum (R7)
      do_entry(0, 10, 3, 1'b1, 0, 0, 1'b0, "R7");
      do_exit (0, 39, 3, 1'b1, 0, 0, 1'b0, "R7");
      do_entry(1, 11, 3, 1'b1, 0, 0, 1'b0, "R7");
      do_exit (1, 40, 3, 1'b1, 0, 0, 1'b0, "R7");
      do_entry(2, 12, 3, 1'b1, 0, 0, 1'b0, "R7");
      do_exit (2, 41, 3, 1'b1, 0, 0, 1'b0, "R7");
      do_entry(63, 63, 3, 1'b1, 0, 0, 1'b0, "R7");
      hold_check(20, 1'b0, 16'h0000, 1'b1, "R4");
      do_exit (63, 63, 3, 1'b1, 0, 0, 1'b0, "R7");
      hold_check(10, 1'b1, 16'hFFFF, 1'b0, "R1");

      // Sweep of all pad-off values with the other waits walked alongside
      for (int k = 0; k < 64; k++) begin
         do_entry(k, (k * 7 + 3) % 64, 3, 1'b1, 0, 0, 1'b0, "");
         do_exit ((k * 13 + 1) % 64, (k * 29 + 5) % 64, 3, 1'b1, 0, 0, 1'b0, "");
      end

      // R9: glitch on the request during entry, then restored
      do_entry(4, 15, 3, 1'b1, 5, 3, 1'b1, "R9");
      hold_check(12, 1'b0, 16'h0000, 1'b1, "R9");
      // R9: glitch during exit, then restored low
      do_exit(6, 45, 3, 1'b1, 8, 4, 1'b1, "R9");
      hold_check(12, 1'b1, 16'hFFFF, 1'b0, "R9");
      // R9: request drops during entry and stays low -> exit starts right after sleep
      do_entry(3, 12, 3, 1'b1, 6, 1, 1'b0, "R9");
      do_exit(2, 40, 1, 1'b0, 0, 0, 1'b0, "R9");
      // R9: request rises during exit and stays high -> entry starts right after wake
      do_entry(2, 11, 3, 1'b1, 0, 0, 1'b0, "");
      do_exit(5, 41, 3, 1'b1, 10, 1, 1'b0, "R9");
      do_entry(1, 20, 1, 1'b0, 0, 0, 1'b0, "R9");
      do_exit(1, 40, 3, 1'b1, 0, 0, 1'b0, "");
      hold_check(5, 1'b1, 16'hFFFF, 1'b0, "R10");

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule